// File: doc/BRIEF.md
# Windowed Address Decoder with Default Target

The block maps a 40-bit physical address to a target identifier. A small bank of programmable windows each describes an inclusive address range at 1 MiB granularity, an enable, a target ID and a pair of security attribute bits. A lookup compares the address against all windows in parallel. The lowest-numbered enabled window that covers the address supplies the target. If no window covers it, the target comes from a global default register, so unmatched traffic is routed rather than faulted.

Software programs the bank through a word-indexed register write/read port. Window 0 is a fixed window for internal configuration space. It comes out of reset enabled, and software writes never change it. The security bits are stored and can be read back, but the block does not enforce them.

Top module: `win_addr_decoder`

## Requirements
- R1: After reset, window 0 is enabled with target CFG_TGT and pages CFG_LO..CFG_HI. Windows 1..NUM_WIN-1 have all registers zero, so they are disabled. The global default target is 0.
- R2: Register word index w*4+f selects window w. The field f is 0 for control, 1 for security, 2 for low page and 3 for high page. Index NUM_WIN*4 is the global register. Read data appears on reg_rdata_o one clock after reg_ridx_i is presented. Unmapped bits and indices read as zero.
- R3: In the control register, bit 0 is the window enable and bits [11:8] are the window target ID.
- R4: In the low and high registers, bits [23:4] hold address bits [39:20]. Bits [3:0] and [31:24] are ignored on write and read as zero.
- R5: A window matches only when its enable is set and low <= lk_addr_i[39:20] <= high. Both bounds are inclusive, so the last byte of the high page hits and the first byte of the next page misses.
- R6: When several enabled windows match, the lowest window index wins.
- R7: On a miss, hit_o is 0, win_idx_o is 0, and tgt_o is the global target held in global register bits [3:0].
- R8: Writes to any register of window 0 are ignored. Its readback and lookups are unchanged.
- R9: In the security register, bit 0 is secure read and bit 1 is secure write. The register stores and reads back these two bits and has no effect on lookups.
- R10: Lookup results (tgt_o, hit_o, win_idx_o) are registered and valid one clock after lk_addr_i is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_widx_i | input | IDX_W | Register write word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_ridx_i | input | IDX_W | Register read word index |
| reg_rdata_o | output | 32 | Registered read data |
| lk_addr_i | input | 40 | Lookup physical address |
| tgt_o | output | 4 | Routed target ID |
| hit_o | output | 1 | A window matched |
| win_idx_o | output | WIN_W | Index of the winning window |

## Verification
The bench probes both inclusive bounds at byte precision: the first byte of the low page, the last byte of the high page and the byte just past it. A design using an exclusive upper compare, or comparing below 1 MiB, would misroute one of these.

Overlapping windows are then tested, with the lower-numbered one switched on and off. A priority encoder that picks the highest index, or one that ignores the enable, would report the wrong index and target.

Writes aimed at window 0 and at the security and page padding bits are checked through readback and lookups. A design that left window 0 writable, or that stored the padding bits, would show different values there.

Random windows with random overlaps then run against a bench model. Many random addresses miss, which exercises the global default path.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
  localparam int ADDR_W       = 40;
  localparam int GRAN_LSB     = 20;
  localparam int PAGE_W       = ADDR_W - GRAN_LSB;
  localparam int TGT_W        = 4;
  localparam int REG_W        = 32;
  localparam int CTRL_TGT_LSB = 8;
  localparam int PAGE_REG_LSB = 4;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [TGT_W-1:0]  tgt_t;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_SEC  = 2'd1,
    FLD_LO   = 2'd2,
    FLD_HI   = 2'd3
  } reg_fld_e;

  typedef struct packed {
    logic       en;
    tgt_t       tgt;
    logic [1:0] sec;
    page_t      lo;
    page_t      hi;
  } win_cfg_t;
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import win_dec_pkg::*;
#(
  parameter int    NUM_WIN = 8,
  parameter int    IDX_W   = 6,
  parameter tgt_t  CFG_TGT = 4'd1,
  parameter page_t CFG_LO  = 20'hF0000,
  parameter page_t CFG_HI  = 20'hF00FF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [REG_W-1:0]        wr_data_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic [REG_W-1:0]        rd_data_o,
  output win_cfg_t [NUM_WIN-1:0]  cfg_o,
  output tgt_t                    glob_tgt_o
);
  localparam int WIN_W    = $clog2(NUM_WIN);
  localparam int WIN_REGS = NUM_WIN * 4;

  logic             wr_in_bank;
  logic [WIN_W-1:0] wr_win;
  reg_fld_e         wr_fld;
  logic             wd_en;
  tgt_t             wd_tgt;
  logic [1:0]       wd_sec;
  page_t            wd_page;

  assign wr_in_bank = wr_en_i && (wr_idx_i < IDX_W'(WIN_REGS));
  assign wr_win     = wr_idx_i[2 +: WIN_W];
  assign wr_fld     = reg_fld_e'(wr_idx_i[1:0]);
  assign wd_en      = wr_data_i[0];
  assign wd_tgt     = wr_data_i[CTRL_TGT_LSB +: TGT_W];
  assign wd_sec     = wr_data_i[1:0];
  assign wd_page    = wr_data_i[PAGE_REG_LSB +: PAGE_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w == 0) begin : g_fixed
      // configuration-space window: constant, never writable
      assign cfg_o[w] = '{en: 1'b1, tgt: CFG_TGT, sec: 2'b00, lo: CFG_LO, hi: CFG_HI};
    end else begin : g_prog
      win_cfg_t cfg_q;
      logic     sel;
      assign sel = wr_in_bank && (wr_win == WIN_W'(w));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cfg_q <= '0;
        end else if (sel) begin
          unique case (wr_fld)
            FLD_CTRL: begin
              cfg_q.en  <= wd_en;
              cfg_q.tgt <= wd_tgt;
            end
            FLD_SEC:  cfg_q.sec <= wd_sec;
            FLD_LO:   cfg_q.lo  <= wd_page;
            FLD_HI:   cfg_q.hi  <= wd_page;
            default:  ;
          endcase
        end
      end
      assign cfg_o[w] = cfg_q;
    end
  end

  tgt_t glob_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      glob_q <= '0;
    else if (wr_en_i && wr_idx_i == IDX_W'(WIN_REGS)) glob_q <= wr_data_i[TGT_W-1:0];
  end
  assign glob_tgt_o = glob_q;

  logic [REG_W-1:0] rd_nxt;
  win_cfg_t         rd_cfg;
  assign rd_cfg = cfg_o[rd_idx_i[2 +: WIN_W]];

  always_comb begin
    rd_nxt = '0;
    if (rd_idx_i == IDX_W'(WIN_REGS)) begin
      rd_nxt[TGT_W-1:0] = glob_q;
    end else if (rd_idx_i < IDX_W'(WIN_REGS)) begin
      unique case (reg_fld_e'(rd_idx_i[1:0]))
        FLD_CTRL: begin
          rd_nxt[0]                      = rd_cfg.en;
          rd_nxt[CTRL_TGT_LSB +: TGT_W]  = rd_cfg.tgt;
        end
        FLD_SEC:  rd_nxt[1:0]                   = rd_cfg.sec;
        FLD_LO:   rd_nxt[PAGE_REG_LSB +: PAGE_W] = rd_cfg.lo;
        FLD_HI:   rd_nxt[PAGE_REG_LSB +: PAGE_W] = rd_cfg.hi;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_nxt;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[REG_W-1:PAGE_REG_LSB+PAGE_W], wr_data_i[CTRL_TGT_LSB-1:TGT_W]};

  // R4
  page_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i < IDX_W'(WIN_REGS) && rd_idx_i[1]) |=>
      (rd_data_o[PAGE_REG_LSB-1:0] == '0 && rd_data_o[REG_W-1:PAGE_REG_LSB+PAGE_W] == '0));

  // R8
  win0_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < IDX_W'(4)) |=> (cfg_o[0].en && cfg_o[0].lo == CFG_LO && cfg_o[0].hi == CFG_HI));
endmodule

// File: rtl/win_match.sv
module win_match
  import win_dec_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  page_t                   page_i,
  input  win_cfg_t [NUM_WIN-1:0]  cfg_i,
  output logic [NUM_WIN-1:0]      match_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    // inclusive on both bounds
    assign match_o[w] = cfg_i[w].en && (page_i >= cfg_i[w].lo) && (page_i <= cfg_i[w].hi);
  end
endmodule

// File: rtl/win_prio_sel.sv
module win_prio_sel #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WIN-1:0] match_i,
  output logic [NUM_WIN-1:0] grant_o,
  output logic [WIN_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = WIN_W'(i);
    end
  end

  assign any_o   = |match_i;
  assign grant_o = any_o ? (NUM_WIN'(1) << idx_o) : '0;

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~match_i) == '0));

  // R6
  grant_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((match_i & (grant_o - NUM_WIN'(1))) == '0));
endmodule

// File: rtl/win_addr_decoder.sv
module win_addr_decoder
  import win_dec_pkg::*;
#(
  parameter int    NUM_WIN = 8,
  parameter tgt_t  CFG_TGT = 4'd1,
  parameter page_t CFG_LO  = 20'hF0000,
  parameter page_t CFG_HI  = 20'hF00FF,
  localparam int   IDX_W   = $clog2(NUM_WIN * 4 + 1),
  localparam int   WIN_W   = $clog2(NUM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_widx_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [IDX_W-1:0]  reg_ridx_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [39:0]       lk_addr_i,
  output logic [3:0]        tgt_o,
  output logic              hit_o,
  output logic [WIN_W-1:0]  win_idx_o
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  tgt_t                   glob_tgt;
  logic [NUM_WIN-1:0]     match_vec;
  logic [NUM_WIN-1:0]     grant;
  logic [WIN_W-1:0]       sel_idx;
  logic                   any_hit;
  page_t                  page;

  assign page = lk_addr_i[ADDR_W-1:GRAN_LSB];

  win_regfile #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W),
    .CFG_TGT (CFG_TGT),
    .CFG_LO  (CFG_LO),
    .CFG_HI  (CFG_HI)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_we_i),
    .wr_idx_i   (reg_widx_i),
    .wr_data_i  (reg_wdata_i),
    .rd_idx_i   (reg_ridx_i),
    .rd_data_o  (reg_rdata_o),
    .cfg_o      (cfg),
    .glob_tgt_o (glob_tgt)
  );

  win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .page_i  (page),
    .cfg_i   (cfg),
    .match_o (match_vec)
  );

  win_prio_sel #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_vec),
    .grant_o (grant),
    .idx_o   (sel_idx),
    .any_o   (any_hit)
  );

  tgt_t sel_tgt;
  always_comb begin
    sel_tgt = glob_tgt;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) sel_tgt = cfg[i].tgt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_o     <= '0;
      hit_o     <= 1'b0;
      win_idx_o <= '0;
    end else begin
      tgt_o     <= sel_tgt;
      hit_o     <= any_hit;
      win_idx_o <= any_hit ? sel_idx : '0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_addr_i[GRAN_LSB-1:0]};

  // R7
  miss_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (tgt_o == $past(glob_tgt) && win_idx_o == '0));

  // R5
  hit_has_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(match_vec) != '0));

  // R10
  hit_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_hit) |=> hit_o);
endmodule

// File: tb/win_addr_decoder_bench.sv
module win_addr_decoder_bench;
  localparam int NW    = 8;
  localparam int IDX_W = $clog2(NW * 4 + 1);
  localparam int WIN_W = $clog2(NW);
  localparam logic [3:0]  C_TGT = 4'd1;
  localparam logic [19:0] C_LO  = 20'hF0000;
  localparam logic [19:0] C_HI  = 20'hF00FF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [IDX_W-1:0] widx = '0;
  logic [31:0]      wdata = '0;
  logic [IDX_W-1:0] ridx = '0;
  logic [31:0]      rdata;
  logic [39:0]      addr = '0;
  logic [3:0]       tgt;
  logic             hit;
  logic [WIN_W-1:0] widx_o;

  always #4 clk = ~clk;

  win_addr_decoder #(.NUM_WIN(NW), .CFG_TGT(C_TGT), .CFG_LO(C_LO), .CFG_HI(C_HI)) u_win_addr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_widx_i(widx), .reg_wdata_i(wdata),
    .reg_ridx_i(ridx), .reg_rdata_o(rdata), .lk_addr_i(addr),
    .tgt_o(tgt), .hit_o(hit), .win_idx_o(widx_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        m_en  [NW];
  logic [3:0]  m_tgt [NW];
  logic [1:0]  m_sec [NW];
  logic [19:0] m_lo  [NW];
  logic [19:0] m_hi  [NW];
  logic [3:0]  m_glob;

  function automatic logic [31:0] model_reg(int idx);
    int w, f;
    logic [31:0] v;
    v = '0;
    if (idx == NW * 4) return {28'b0, m_glob};
    if (idx > NW * 4) return '0;
    w = idx / 4; f = idx % 4;
    case (f)
      0: v = {20'b0, m_tgt[w], 7'b0, m_en[w]};
      1: v = {30'b0, m_sec[w]};
      2: v = {8'b0, m_lo[w], 4'b0};
      default: v = {8'b0, m_hi[w], 4'b0};
    endcase
    return v;
  endfunction

  // returns {hit, idx, tgt}
  function automatic logic [WIN_W+4:0] model_lk(logic [39:0] a);
    logic [19:0] p;
    p = a[39:20];
    for (int w = 0; w < NW; w++)
      if (m_en[w] && p >= m_lo[w] && p <= m_hi[w]) return {1'b1, WIN_W'(w), m_tgt[w]};
    return {1'b0, WIN_W'(0), m_glob};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    int w, f;
    @(negedge clk);
    we = 1'b1; widx = IDX_W'(idx); wdata = d;
    @(negedge clk);
    we = 1'b0;
    w = idx / 4; f = idx % 4;
    if (idx == NW * 4) m_glob = d[3:0];
    else if (idx < NW * 4 && w != 0) begin
      case (f)
        0: begin m_en[w] = d[0]; m_tgt[w] = d[11:8]; end
        1: m_sec[w] = d[1:0];
        2: m_lo[w] = d[23:4];
        default: m_hi[w] = d[23:4];
      endcase
    end
  endtask

  task automatic rd_chk(int idx, string req);
    @(negedge clk);
    ridx = IDX_W'(idx);
    @(negedge clk);
    chk(req, rdata, model_reg(idx));
  endtask

  task automatic lk_chk(logic [39:0] a, string req);
    logic [WIN_W+4:0] e;
    @(negedge clk);
    addr = a;
    @(negedge clk);
    e = model_lk(a);
    chk({req, " hit"}, {31'b0, hit}, {31'b0, e[WIN_W+4]});
    chk({req, " idx"}, 32'(widx_o), 32'(e[WIN_W+3:4]));
    chk({req, " tgt"}, {28'b0, tgt}, {28'b0, e[3:0]});
  endtask

  function automatic logic [31:0] ctrl(logic en, logic [3:0] t);
    return {20'b0, t, 7'b0, en};
  endfunction

  function automatic logic [31:0] pg(logic [19:0] p);
    return {8'b0, p, 4'b0};
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int w = 0; w < NW; w++) begin
      m_en[w] = 0; m_tgt[w] = 0; m_sec[w] = 0; m_lo[w] = 0; m_hi[w] = 0;
    end
    m_en[0] = 1; m_tgt[0] = C_TGT; m_lo[0] = C_LO; m_hi[0] = C_HI; m_glob = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R10 reset hit", {31'b0, hit}, 32'd0);
    rd_chk(0, "R1 win0 ctrl");
    chk("R1 win0 ctrl literal", rdata, 32'h0000_0101);
    rd_chk(2, "R1 win0 lo");
    rd_chk(3, "R1 win0 hi");
    rd_chk(3 * 4, "R1 win3 ctrl");
    rd_chk(NW * 4, "R1 global");
    rd_chk(NW * 4 + 1, "R2 unmapped");
    lk_chk(40'hF0_0000_0000, "R1 cfg low edge");
    lk_chk(40'hF0_0FFF_FFFF, "R5 cfg high edge");
    lk_chk(40'hF0_1000_0000, "R7 past cfg");
    // R8 window 0 write ignored
    wr(0, 32'h0);
    wr(2, pg(20'h00001));
    rd_chk(0, "R8 win0 ctrl kept");
    rd_chk(2, "R8 win0 lo kept");
    lk_chk(40'hF0_0000_0000, "R8 win0 still hit");
    // R3 R5 program window 2, inclusive bounds
    wr(2 * 4 + 2, pg(20'h00100));
    wr(2 * 4 + 3, pg(20'h0010F));
    wr(2 * 4 + 0, ctrl(1'b1, 4'd5));
    rd_chk(2 * 4, "R3 win2 ctrl");
    lk_chk({20'h00100, 20'h00000}, "R5 lo first byte");
    lk_chk({20'h0010F, 20'hFFFFF}, "R5 hi last byte");
    lk_chk({20'h00110, 20'h00000}, "R5 hi plus one");
    lk_chk({20'h000FF, 20'hFFFFF}, "R5 below lo");
    // R6 overlap
    wr(1 * 4 + 2, pg(20'h00108));
    wr(1 * 4 + 3, pg(20'h00200));
    wr(1 * 4 + 0, ctrl(1'b1, 4'd7));
    lk_chk({20'h00108, 20'h12345}, "R6 overlap lower wins");
    chk("R6 overlap idx literal", 32'(widx_o), 32'd1);
    lk_chk({20'h00105, 20'h0}, "R6 only win2");
    // R3 disable
    wr(1 * 4 + 0, ctrl(1'b0, 4'd7));
    rd_chk(1 * 4, "R3 disabled ctrl");
    lk_chk({20'h00108, 20'h0}, "R3 disabled skipped");
    lk_chk({20'h00150, 20'h0}, "R3 disabled miss");
    // R7 global
    wr(NW * 4, 32'hFFFF_FFF9);
    rd_chk(NW * 4, "R7 global readback");
    lk_chk({20'h00300, 20'h0}, "R7 miss global");
    chk("R7 global literal", {28'b0, tgt}, 32'd9);
    // R9 security
    wr(2 * 4 + 1, 32'hFFFF_FFFE);
    rd_chk(2 * 4 + 1, "R9 sec readback");
    chk("R9 sec literal", rdata, 32'd2);
    lk_chk({20'h00101, 20'h0}, "R9 sec no effect");
    // R4 padding
    wr(7 * 4 + 2, 32'hFFFF_FFFF);
    rd_chk(7 * 4 + 2, "R4 lo pad");
    chk("R4 lo pad literal", rdata, 32'h00FF_FFF0);
    // random phase
    for (int it = 0; it < 60; it++) begin
      int w;
      logic [19:0] lo;
      w  = 1 + int'($urandom_range(NW - 2));
      lo = 20'($urandom_range(63));
      wr(w * 4 + 2, pg(lo) | 32'($urandom_range(15)));
      wr(w * 4 + 3, pg(lo + 20'($urandom_range(15))));
      wr(w * 4 + 0, ctrl(1'($urandom_range(3) != 0), 4'($urandom())));
      if ($urandom_range(7) == 0) wr(NW * 4, $urandom());
      if ($urandom_range(3) == 0) rd_chk(int'($urandom_range(NW * 4)), "R2 random read");
      for (int k = 0; k < 8; k++) begin
        lk_chk({20'($urandom_range(90)), 20'($urandom())}, "R6 random lookup");
      end
    end
    done = 1;
    report();
  end
endmodule